// File: doc/BRIEF.md
# Converter Conversion Sequencer with Locked Channel Selection

This block is the digital controller that sits around a successive-approximation converter. It counts each conversion in half periods of the converter clock, fires a one-pulse sample-and-hold strobe at the right instant, raises a sticky completion flag and latches the conversion result. The analog part is replaced by a result input bus that is captured at completion.

The channel and reference selection lives in two stages. Software writes a shadow buffer at any time. A live copy follows that buffer while the converter is idle. Once a conversion begins, the live copy is frozen. It opens again for the final converter clock period of the conversion.

Conversions are started in one of three ways: by writing the start bit, by an external trigger pulse when auto-triggering is on, or back-to-back in free-running mode. The length of a conversion and its sample instant depend on whether it is the first one after enabling, a normal one, or a triggered one.

The converter clock is given as a strobe `half_en` that pulses once per half period. The pulses alternate between rising and falling converter edges. The first pulse after reset is a rising edge.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Writing `wr_sel` stores `wr_data` in the selection buffer at any time. While no conversion runs, `sel_live` equals the buffer one clock after the write.
- R2: From the start of a conversion, `sel_live` holds the value it had at that start. It follows the buffer again during the last two half ticks of the conversion, and it has caught up by the final half tick.
- R3: A control write (`wr_ctl`) with bit0 (enable) and bit1 (start) both set requests a conversion. `start_rb` reads 1 from the clock after the write until completion. The conversion begins only on a half tick that is a rising converter edge, which is an even-numbered half tick counting from 0.
- R4: The first conversion after enable completes 50 half ticks after its start, and `sample_stb` pulses 27 half ticks after its start.
- R5: A normal started conversion completes after 26 half ticks, and `sample_stb` pulses at half tick 3.
- R6: When control bit2 (auto-trigger) and enable are set, a `trig` pulse starts a conversion on the next half tick of either phase. Such a conversion completes after 27 half ticks, with `sample_stb` at half tick 4. With bit2 clear, `trig` has no effect.
- R7: On completion, `busy` falls, `done` is set, `start_rb` clears, and `result` holds `conv_data` sign-extended to 16 bits. The upper byte carries the sign and MSB, and the lower byte carries the LSB.
- R8: With bit2 and bit3 (free-run) set, the next conversion starts on the very next half tick after a completion, and it is timed as a triggered conversion.
- R9: A control write with bit4 set clears `done`. A control write with bit4 clear leaves `done` unchanged.
- R10: Clearing enable aborts any pending or running conversion without setting `done`. It makes the selection transparent, and the next conversion counts as a first conversion.
- R11: After reset, `busy`, `start_rb`, `done`, `sample_stb`, `result` and `sel_live` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_en | input | 1 | One pulse per converter clock half period |
| wr_sel | input | 1 | Write strobe for the selection buffer |
| wr_ctl | input | 1 | Write strobe for the control bits |
| wr_data | input | 8 | Write data (selection, or control bits 0..4) |
| trig | input | 1 | External trigger pulse |
| conv_data | input | 10 | Raw signed converter result |
| sel_live | output | 8 | Selection applied to the converter |
| sample_stb | output | 1 | Sample-and-hold strobe |
| busy | output | 1 | Conversion running |
| start_rb | output | 1 | Start bit readback |
| done | output | 1 | Sticky completion flag |
| result | output | 16 | Latched sign-extended result |

## Verification
The hardest case is a selection change that arrives while a conversion is already underway. It must be withheld from the live copy for most of the conversion and then show up before completion. The stimulus reaches this by waiting until the bench's own half-tick count reads 2 inside a conversion and then writing a new selection. The live value is checked at half tick 5 and again at the next-to-last half tick, for all three conversion kinds. Free-running back-to-back starts and an enable cleared mid-conversion are driven directly. Random rounds mix manual and triggered conversions with random result data.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    CONV_FIRST  = 2'd0,
    CONV_NORMAL = 2'd1,
    CONV_AUTO   = 2'd2
  } conv_kind_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_START = 1;
  localparam int CTL_AUTO  = 2;
  localparam int CTL_FREE  = 3;
  localparam int CTL_DCLR  = 4;
endpackage

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow #(
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic [SEL_W-1:0] wr_val,
  input  logic             sel_open,
  output logic [SEL_W-1:0] sel_live
);
  logic [SEL_W-1:0] buf_q, buf_d, live_q, live_d;

  always_comb begin
    buf_d  = wr_sel ? wr_val : buf_q;
    live_d = sel_open ? buf_q : live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      live_q <= '0;
    end else begin
      buf_q  <= buf_d;
      live_q <= live_d;
    end
  end

  assign sel_live = live_q;

  assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_open |=> $stable(live_q));
  assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_open |=> live_q == $past(buf_q));
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int CW        = 6,
  parameter int FIRST_LEN = 50,
  parameter int FIRST_SMP = 27,
  parameter int NORM_LEN  = 26,
  parameter int NORM_SMP  = 3,
  parameter int AUTO_LEN  = 27,
  parameter int AUTO_SMP  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_en,
  input  logic en,
  input  logic start_req,
  input  logic trig_req,
  input  logic free_run,
  output logic busy,
  output logic start_rb,
  output logic sample_stb,
  output logic done_pulse,
  output logic sel_open
);
  logic          phase_q, phase_d;
  logic          pend_q, pend_d;
  logic          pauto_q, pauto_d;
  logic          run_q, run_d;
  logic          first_q, first_d;
  conv_kind_e    kind_q, kind_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          smp_q, smp_d, done_q, done_d;
  logic [CW-1:0] len_cur, smp_cur;

  always_comb begin
    case (kind_q)
      CONV_FIRST:  begin len_cur = CW'(FIRST_LEN); smp_cur = CW'(FIRST_SMP); end
      CONV_AUTO:   begin len_cur = CW'(AUTO_LEN);  smp_cur = CW'(AUTO_SMP);  end
      default:     begin len_cur = CW'(NORM_LEN);  smp_cur = CW'(NORM_SMP);  end
    endcase
  end

  assign cnt_inc = cnt_q + CW'(1);

  always_comb begin
    phase_d = half_en ? ~phase_q : phase_q;
    pend_d  = pend_q;
    pauto_d = pauto_q;
    run_d   = run_q;
    first_d = first_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    smp_d   = 1'b0;
    done_d  = 1'b0;
    if (!en) begin
      pend_d  = 1'b0;
      run_d   = 1'b0;
      first_d = 1'b1;
      cnt_d   = '0;
    end else begin
      if (!run_q && !pend_q && start_req) begin
        pend_d  = 1'b1;
        pauto_d = 1'b0;
      end
      if (!run_q && !pend_q && trig_req) begin
        pend_d  = 1'b1;
        pauto_d = 1'b1;
      end
      if (half_en) begin
        if (run_q) begin
          if (cnt_inc == len_cur) begin
            run_d  = 1'b0;
            done_d = 1'b1;
            if (free_run) begin
              pend_d  = 1'b1;
              pauto_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_inc;
          end
          if (cnt_inc == smp_cur) smp_d = 1'b1;
        end else if (pend_q && (pauto_q || !phase_q)) begin
          run_d   = 1'b1;
          pend_d  = 1'b0;
          cnt_d   = '0;
          first_d = 1'b0;
          kind_d  = first_q ? CONV_FIRST : (pauto_q ? CONV_AUTO : CONV_NORMAL);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      pend_q  <= 1'b0;
      pauto_q <= 1'b0;
      run_q   <= 1'b0;
      first_q <= 1'b1;
      kind_q  <= CONV_FIRST;
      cnt_q   <= '0;
      smp_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pend_q  <= pend_d;
      pauto_q <= pauto_d;
      run_q   <= run_d;
      first_q <= first_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      smp_q   <= smp_d;
      done_q  <= done_d;
    end
  end

  assign busy       = run_q;
  assign start_rb   = run_q | pend_q;
  assign sample_stb = smp_q;
  assign done_pulse = done_q;
  assign sel_open   = !run_q || (cnt_q >= len_cur - CW'(2));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !run_q && !pend_q && !done_q);
  assert_start_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(half_en));
  assert_done_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !run_q && $past(run_q));
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_q && done_q));
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int RES_W = 10,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_pulse,
  input  logic             done_clr,
  input  logic [RES_W-1:0] conv_data,
  output logic             done,
  output logic [OUT_W-1:0] result
);
  localparam int EXT_W = OUT_W - RES_W;

  logic             flag_q, flag_d;
  logic [OUT_W-1:0] res_q, res_d, ext_val;

  assign ext_val = {{EXT_W{conv_data[RES_W-1]}}, conv_data};

  always_comb begin
    flag_d = flag_q;
    res_d  = res_q;
    if (done_clr) flag_d = 1'b0;
    if (done_pulse) begin
      flag_d = 1'b1;
      res_d  = ext_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      res_q  <= '0;
    end else begin
      flag_q <= flag_d;
      res_q  <= res_d;
    end
  end

  assign done   = flag_q;
  assign result = res_q;

  assert_done_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> flag_q);
  assert_done_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !done_pulse) |=> !flag_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DW        = 8,
  parameter int RES_W     = 10,
  parameter int OUT_W     = 16,
  parameter int FIRST_LEN = 50,
  parameter int FIRST_SMP = 27,
  parameter int NORM_LEN  = 26,
  parameter int NORM_SMP  = 3,
  parameter int AUTO_LEN  = 27,
  parameter int AUTO_SMP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_en,
  input  logic             wr_sel,
  input  logic             wr_ctl,
  input  logic [DW-1:0]    wr_data,
  input  logic             trig,
  input  logic [RES_W-1:0] conv_data,
  output logic [DW-1:0]    sel_live,
  output logic             sample_stb,
  output logic             busy,
  output logic             start_rb,
  output logic             done,
  output logic [OUT_W-1:0] result
);
  localparam int CW = $clog2(FIRST_LEN + 1);

  logic       rs_q1, rs_q2, srst_n;
  logic       en_q, auto_q, free_q;
  logic       en_d, auto_d, free_d;
  logic       start_req, trig_req, done_clr, done_pulse, sel_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign srst_n = rs_q2;

  always_comb begin
    en_d   = en_q;
    auto_d = auto_q;
    free_d = free_q;
    if (wr_ctl) begin
      en_d   = wr_data[CTL_EN];
      auto_d = wr_data[CTL_AUTO];
      free_d = wr_data[CTL_FREE];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      free_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      auto_q <= auto_d;
      free_q <= free_d;
    end
  end

  assign start_req = wr_ctl && wr_data[CTL_START] && wr_data[CTL_EN];
  assign trig_req  = trig && auto_q && en_d;
  assign done_clr  = wr_ctl && wr_data[CTL_DCLR];

  adc_sel_shadow #(.SEL_W(DW)) u_shadow (
    .clk(clk), .rst_n(srst_n), .wr_sel(wr_sel), .wr_val(wr_data),
    .sel_open(sel_open), .sel_live(sel_live)
  );

  adc_conv_timer #(
    .CW(CW), .FIRST_LEN(FIRST_LEN), .FIRST_SMP(FIRST_SMP),
    .NORM_LEN(NORM_LEN), .NORM_SMP(NORM_SMP),
    .AUTO_LEN(AUTO_LEN), .AUTO_SMP(AUTO_SMP)
  ) u_timer (
    .clk(clk), .rst_n(srst_n), .half_en(half_en), .en(en_d),
    .start_req(start_req), .trig_req(trig_req), .free_run(auto_d && free_d),
    .busy(busy), .start_rb(start_rb), .sample_stb(sample_stb),
    .done_pulse(done_pulse), .sel_open(sel_open)
  );

  adc_result_reg #(.RES_W(RES_W), .OUT_W(OUT_W)) u_result (
    .clk(clk), .rst_n(srst_n), .done_pulse(done_pulse), .done_clr(done_clr),
    .conv_data(conv_data), .done(done), .result(result)
  );

  assert_trig_gated_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (!start_rb && !auto_q && !start_req) |=> !start_rb);
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_en = 1'b0;
  logic        wr_sel = 1'b0, wr_ctl = 1'b0, trig = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [9:0]  conv_data = '0;
  logic [7:0]  sel_live;
  logic        sample_stb, busy, start_rb, done;
  logic [15:0] result;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .wr_sel(wr_sel),
    .wr_ctl(wr_ctl), .wr_data(wr_data), .trig(trig), .conv_data(conv_data),
    .sel_live(sel_live), .sample_stb(sample_stb), .busy(busy),
    .start_rb(start_rb), .done(done), .result(result)
  );

  always #5 clk = ~clk;

  int chk = 0, fail = 0;
  int hidx = 0, hc = 0, exp_l = 0, exp_s = 0, done_cnt = 0, done_idx = 0, tick = 0;
  int kind = 0, cur_mode = 0;
  bit bfirst = 1, free_exp = 0, fr_armed = 0, halves_on = 0, busy_p = 0, done_p = 0;
  logic [7:0] sel_buf = '0, sel_start = '0, ctl_base = '0;
  string lreq;

  task automatic check(string req, int act, int exp);
    chk++;
    if (act != exp) begin
      fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sext16(logic [9:0] v);
    return int'({{6{v[9]}}, v});
  endfunction

  function automatic int len_of(int m);
    return (m == 0) ? 50 : (m == 1) ? 26 : 27;
  endfunction

  function automatic int smp_of(int m);
    return (m == 0) ? 27 : (m == 1) ? 3 : 4;
  endfunction

  // monitor and half-tick driver
  always @(negedge clk) begin
    bit step;
    step = 0;
    if (half_en) begin hidx++; hc++; step = 1; end
    if (busy && !busy_p) begin
      hc = 0;
      cur_mode = bfirst ? 0 : (kind ? 2 : 1);
      bfirst = 0;
      exp_l = len_of(cur_mode);
      exp_s = smp_of(cur_mode);
      lreq = (cur_mode == 0) ? "R4" : (cur_mode == 1) ? "R5" : "R6";
      sel_start = sel_live;
      check("R1", sel_live, sel_buf);
      if (kind == 0) check("R3", (hidx - 1) % 2, 0);
      if (free_exp && fr_armed) check("R8", hidx - 1 - done_idx, 1);
      step = 0;
    end
    if (step && busy) begin
      if (hc == 5) check("R2", sel_live, sel_start);
      if (hc == exp_l - 1) check("R2", sel_live, sel_buf);
    end
    if (sample_stb) check(lreq, hc, exp_s);
    if (done && !done_p) begin
      check(lreq, hc, exp_l);
      check("R7", result, sext16(conv_data));
      check("R7", busy, 0);
      if (!free_exp) check("R7", start_rb, 0);
      done_idx = hidx - 1;
      fr_armed = free_exp;
      done_cnt++;
    end
    busy_p = busy;
    done_p = done;
    tick++;
    half_en = halves_on && (tick % 4 == 0);
  end

  task automatic ctl_write(logic [7:0] d);
    @(negedge clk); #1;
    wr_ctl = 1'b1; wr_data = d;
    @(negedge clk); #1;
    wr_ctl = 1'b0;
  endtask

  task automatic sel_write(logic [7:0] d);
    @(negedge clk); #1;
    wr_sel = 1'b1; wr_data = d; sel_buf = d;
    @(negedge clk); #1;
    wr_sel = 1'b0;
  endtask

  task automatic conv(int k, bit chg);
    int dc;
    dc = done_cnt;
    kind = k;
    conv_data = 10'($urandom);
    if (k == 0) begin
      ctl_write(ctl_base | 8'h02);
      check("R3", start_rb, 1);
    end else begin
      @(negedge clk); #1; trig = 1'b1;
      @(negedge clk); #1; trig = 1'b0;
    end
    if (chg) begin
      while (!(busy && hc == 2)) begin @(negedge clk); #1; end
      sel_write(8'($urandom));
    end
    while (done_cnt == dc) begin @(negedge clk); #1; end
    ctl_write(ctl_base | 8'h10);
    @(negedge clk); #1;
    check("R9", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", chk, fail);
    $finish;
  end

  initial begin
    int dc;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", busy, 0);
    check("R11", start_rb, 0);
    check("R11", done, 0);
    check("R11", result, 0);
    check("R11", sel_live, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    halves_on = 1;
    sel_write(8'h5A);
    @(negedge clk); #1;
    check("R1", sel_live, 8'h5A);
    // first conversion, then R9 write without clear bit
    ctl_base = 8'h01;
    ctl_write(8'h01);
    bfirst = 1;
    dc = done_cnt;
    kind = 0;
    conv_data = 10'h2A5;
    ctl_write(8'h03);
    check("R3", start_rb, 1);
    while (done_cnt == dc) begin @(negedge clk); #1; end
    ctl_write(8'h01);
    @(negedge clk); #1;
    check("R9", done, 1);
    ctl_write(8'h11);
    @(negedge clk); #1;
    check("R9", done, 0);
    // normal conversions with selection change mid-way
    conv(0, 1);
    conv(0, 0);
    // trigger ignored while auto is off
    @(negedge clk); #1; trig = 1'b1;
    @(negedge clk); #1; trig = 1'b0;
    repeat (40) @(negedge clk);
    #1;
    check("R6", start_rb, 0);
    check("R6", busy, 0);
    // triggered conversions
    ctl_base = 8'h05;
    ctl_write(ctl_base);
    conv(1, 1);
    conv(1, 0);
    // free-running
    ctl_base = 8'h0D;
    free_exp = 1; fr_armed = 0;
    ctl_write(ctl_base);
    kind = 1;
    @(negedge clk); #1; trig = 1'b1;
    @(negedge clk); #1; trig = 1'b0;
    for (int i = 0; i < 3; i++) begin
      dc = done_cnt;
      while (done_cnt == dc) begin @(negedge clk); #1; end
      if (i == 2) ctl_base = 8'h05;
      ctl_write(ctl_base | 8'h10);
    end
    while (start_rb) begin @(negedge clk); #1; end
    dc = done_cnt;
    while (done_cnt == dc && busy) begin @(negedge clk); #1; end
    free_exp = 0; fr_armed = 0;
    ctl_write(8'h15);
    repeat (120) @(negedge clk);
    #1;
    check("R8", start_rb, 0);
    // abort by clearing enable
    ctl_base = 8'h01;
    ctl_write(8'h11);
    kind = 0;
    ctl_write(8'h03);
    repeat (30) @(negedge clk);
    #1;
    check("R10", busy, 1);
    ctl_write(8'h00);
    check("R10", busy, 0);
    check("R10", start_rb, 0);
    bfirst = 1;
    sel_write(8'hC3);
    @(negedge clk); #1;
    check("R10", sel_live, 8'hC3);
    repeat (250) @(negedge clk);
    #1;
    check("R10", done, 0);
    ctl_write(8'h01);
    conv(0, 1);
    // random rounds
    for (int i = 0; i < 16; i++) begin
      int k;
      k = int'($urandom % 2);
      ctl_base = k ? 8'h05 : 8'h01;
      ctl_write(ctl_base);
      if ($urandom % 2) sel_write(8'($urandom));
      conv(k, bit'($urandom % 2));
    end
    $display("TB_RESULT checks=%0d failures=%0d", chk, fail);
    $finish;
  end
endmodule